// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that walks a ring of link descriptors kept in a small descriptor memory. Each descriptor occupies four consecutive 32-bit words. In word order they are the source address, the destination address, the byte count and the word address of the next descriptor. The channel fetches a descriptor and moves its bytes one beat at a time through a synchronous data-memory port. It then follows the next pointer. When the last descriptor points back to the first, the channel loops with no software help. This suits a streaming buffer that is split into periods.

Either end of a transfer can be held at a fixed address, such as a peripheral data register, while the other end advances. The beat size is 1, 2, 4 or 8 bytes. Data on the memory port is right-justified. A peripheral can gate the channel in two ways. With an external start enable, the channel waits for a start strobe before it fetches the first descriptor. With an external pause enable, the channel checks a pause input after every burst of a programmed number of bytes. Software drives the channel through a small register port. Status flags are cleared by writing 1, and one interrupt line reports end of segment and errors.

Top module: `chain_dma_channel`

## Requirements
- R1: Word offsets 0, 1, 2 and 3 from the descriptor pointer hold source, destination, byte count and next pointer. The channel starts at RING_BASE (register 2), follows each next pointer and loops indefinitely around a closed ring.
- R2: Each completed descriptor sets STATUS bit 0 (segment done). If the completed descriptor's next pointer equals RING_BASE, it also sets STATUS bit 1 (list end).
- R3: `irq` is high while (STATUS bit 0 and MODE bit 6) or ((STATUS bit 2 or bit 3) and MODE bit 7) holds. It changes on the same edge as the status bits.
- R4: MODE bit 2 holds the source address and MODE bit 3 holds the destination address. A held side keeps its address, and a free side advances by the beat size after every beat. Each write carries the bytes just read at the source, right-justified, with `mem_size` equal to the beat size.
- R5: The beat size is MODE[11:8] in bytes. A start request with a value other than 1, 2, 4 or 8 sets STATUS bit 2 (programming error) and leaves the channel idle. A fetched descriptor whose count is zero or not a multiple of the beat size does the same.
- R6: When MODE bit 5 (external pause) is set, the channel stops after each 2^MODE[15:12] bytes of a segment. It resumes only while `periph_pause` is low.
- R7: When MODE bit 4 (external start) is set, a start request arms the channel. The first descriptor fetch waits for `periph_start`.
- R8: A start request with external pause enabled while BYTE_CNT (register 3) is non-zero sets STATUS bit 2 and does not start.
- R9: Writing 1 to bits 3:0 of STATUS clears those flags. Writing 0 leaves them unchanged.
- R10: Writing 1 to MODE bit 1 stops the channel and returns it to idle on the next clock. STATUS bit 4 (busy) is low afterwards.
- R11: `mem_err` returned with read data sets STATUS bit 3 (transfer error), suppresses that write and halts the channel.
- R12: Registers 3, 4 and 5 read the live remaining byte count, current source address and current destination address. STATUS bit 4 is high from the first descriptor fetch until the channel is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| desc_rd | output | 1 | Descriptor memory read enable |
| desc_addr | output | DESC_AW | Descriptor memory word address |
| desc_rdata | input | 32 | Descriptor word, one cycle after `desc_rd` |
| mem_re | output | 1 | Data memory read enable |
| mem_we | output | 1 | Data memory write enable |
| mem_addr | output | ADDR_W | Data memory byte address |
| mem_size | output | 4 | Beat size in bytes |
| mem_wdata | output | DATA_W | Right-justified write data |
| mem_rdata | input | DATA_W | Right-justified read data, one cycle after `mem_re` |
| mem_err | input | 1 | Error flag returned with read data |
| periph_start | input | 1 | Peripheral start request |
| periph_pause | input | 1 | Peripheral pause request |
| irq | output | 1 | Interrupt |

## Verification
The bench targets the wrap from the last descriptor back to the first. An engine that did not reload the destination from the descriptor, or did not follow the next pointer, would write to the wrong addresses in the second lap, and the scoreboard would flag those writes. Held addresses with 2- and 4-byte beats are checked because a wrong address step would send writes away from the peripheral register. The pause window is checked by counting exactly four single-byte writes before the channel stalls. An off-by-one burst counter would show five or three. Rejected starts (3-byte beat, zero count, non-zero byte count with external pause) and a read error must produce the flag and no write at all. A channel that went busy first would leak a transfer.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_BASE = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_SRC  = 3'd4;
  localparam logic [2:0] A_DST  = 3'd5;

  typedef enum logic [2:0] {E_IDLE, E_ARM, E_FETCH, E_READ, E_WRITE, E_PAUSE} eng_state_t;

  typedef struct packed {
    logic [3:0] bwc_log2;
    logic [3:0] beat_bytes;
    logic       err_ie;
    logic       seg_ie;
    logic       ext_pause;
    logic       ext_start;
    logic       dst_hold;
    logic       src_hold;
  } mode_t;
endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DESC_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output mode_t              mode_o,
  output logic [DESC_AW-1:0] base_o,
  output logic               go_o,
  output logic               abort_o,
  output logic               cnt_wr_o,
  output logic [31:0]        cnt_wdata_o,
  input  logic               busy_i,
  input  logic               seg_set_i,
  input  logic               lend_set_i,
  input  logic               perr_set_i,
  input  logic               xerr_set_i,
  input  logic [ADDR_W-1:0]  cur_src_i,
  input  logic [ADDR_W-1:0]  cur_dst_i,
  input  logic [31:0]        cnt_i,
  output logic               irq_o
);
  logic [3:0] stat_q, stat_n, clr;
  logic       wr_mode, wr_stat;

  assign wr_mode = reg_we && (reg_addr == A_MODE);
  assign wr_stat = reg_we && (reg_addr == A_STAT);
  assign clr     = wr_stat ? reg_wdata[3:0] : 4'b0;
  assign stat_n  = {xerr_set_i, perr_set_i, lend_set_i, seg_set_i} | (stat_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o      <= '0;
      base_o      <= '0;
      go_o        <= 1'b0;
      abort_o     <= 1'b0;
      cnt_wr_o    <= 1'b0;
      cnt_wdata_o <= '0;
      stat_q      <= '0;
      irq_o       <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      go_o        <= wr_mode && reg_wdata[0];
      abort_o     <= wr_mode && reg_wdata[1];
      cnt_wr_o    <= reg_we && (reg_addr == A_CNT);
      cnt_wdata_o <= reg_wdata;
      if (wr_mode) mode_o <= mode_t'(reg_wdata[15:2]);
      if (reg_we && (reg_addr == A_BASE)) base_o <= reg_wdata[DESC_AW-1:0];
      stat_q <= stat_n;
      irq_o  <= (stat_n[0] && mode_o.seg_ie) || ((stat_n[2] || stat_n[3]) && mode_o.err_ie);
      case (reg_addr)
        A_MODE:  reg_rdata <= {16'b0, mode_o, 2'b00};
        A_STAT:  reg_rdata <= {27'b0, busy_i, stat_q};
        A_BASE:  reg_rdata <= 32'(base_o);
        A_CNT:   reg_rdata <= cnt_i;
        A_SRC:   reg_rdata <= 32'(cur_src_i);
        A_DST:   reg_rdata <= 32'(cur_dst_i);
        default: reg_rdata <= '0;
      endcase
    end
  end

  AST_SEG_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    seg_set_i |=> stat_q[0]); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[0] && !seg_set_i) |=> !stat_q[0]); // R9
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !reg_wdata[2] && stat_q[2]) |=> stat_q[2]); // R9
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DESC_AW = 6,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  mode_t              mode,
  input  logic [DESC_AW-1:0] base,
  input  logic               go,
  input  logic               abort,
  input  logic               cnt_wr,
  input  logic [31:0]        cnt_wdata,
  input  logic               periph_start,
  input  logic               periph_pause,
  output logic               desc_rd,
  output logic [DESC_AW-1:0] desc_addr,
  input  logic [31:0]        desc_rdata,
  output logic               mem_re,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [3:0]         mem_size,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_err,
  output logic               busy,
  output logic               seg_set,
  output logic               lend_set,
  output logic               perr_set,
  output logic               xerr_set,
  output logic [ADDR_W-1:0]  cur_src,
  output logic [ADDR_W-1:0]  cur_dst,
  output logic [31:0]        cnt_q
);
  localparam int DESC_WORDS = 4;
  localparam int ACC_W      = 17;

  eng_state_t         st;
  logic [2:0]         fidx;
  logic [DESC_AW-1:0] ptr, nxt;
  logic [ACC_W-1:0]   acc, acc_nx, bwc_lim;
  logic [ADDR_W-1:0]  step;
  logic [31:0]        sz32;
  logic               size_ok;
  logic [31:DESC_AW]  unused_desc_hi;

  assign unused_desc_hi = desc_rdata[31:DESC_AW];
  assign step    = ADDR_W'(mode.beat_bytes);
  assign sz32    = 32'(mode.beat_bytes);
  assign size_ok = (mode.beat_bytes != 4'd0) &&
                   ((mode.beat_bytes & (mode.beat_bytes - 4'd1)) == 4'd0);
  assign acc_nx  = acc + ACC_W'(mode.beat_bytes);
  assign bwc_lim = ACC_W'(1) << mode.bwc_log2;

  assign desc_rd   = (st == E_FETCH) && (fidx < 3'(DESC_WORDS));
  assign desc_addr = ptr + DESC_AW'(fidx);
  assign mem_re    = (st == E_READ);
  assign mem_we    = (st == E_WRITE) && !mem_err;
  assign mem_addr  = (st == E_WRITE) ? cur_dst : cur_src;
  assign mem_size  = mode.beat_bytes;
  assign mem_wdata = mem_rdata;
  assign busy      = (st != E_IDLE) && (st != E_ARM);

  always_ff @(posedge clk) begin
    seg_set  <= 1'b0;
    lend_set <= 1'b0;
    perr_set <= 1'b0;
    xerr_set <= 1'b0;
    if (rst) begin
      st      <= E_IDLE;
      fidx    <= '0;
      ptr     <= '0;
      nxt     <= '0;
      acc     <= '0;
      cur_src <= '0;
      cur_dst <= '0;
      cnt_q   <= '0;
    end else if (abort) begin
      st  <= E_IDLE;
      acc <= '0;
    end else begin
      case (st)
        E_IDLE: begin
          if (cnt_wr) cnt_q <= cnt_wdata;
          if (go) begin
            if (!size_ok || (mode.ext_pause && cnt_q != 32'd0)) begin
              perr_set <= 1'b1;
            end else if (mode.ext_start) begin
              st <= E_ARM;
            end else begin
              st   <= E_FETCH;
              fidx <= '0;
              ptr  <= base;
            end
          end
        end
        E_ARM: begin
          if (periph_start) begin
            st   <= E_FETCH;
            fidx <= '0;
            ptr  <= base;
          end
        end
        E_FETCH: begin
          fidx <= fidx + 3'd1;
          case (fidx)
            3'd1: cur_src <= desc_rdata[ADDR_W-1:0];
            3'd2: cur_dst <= desc_rdata[ADDR_W-1:0];
            3'd3: cnt_q   <= desc_rdata;
            3'd4: begin
              nxt <= desc_rdata[DESC_AW-1:0];
              acc <= '0;
              if (cnt_q == 32'd0 || (cnt_q & (sz32 - 32'd1)) != 32'd0) begin
                perr_set <= 1'b1;
                st       <= E_IDLE;
              end else begin
                st <= E_READ;
              end
            end
            default: ;
          endcase
        end
        E_READ: st <= E_WRITE;
        E_WRITE: begin
          if (mem_err) begin
            xerr_set <= 1'b1;
            st       <= E_IDLE;
          end else begin
            if (!mode.src_hold) cur_src <= cur_src + step;
            if (!mode.dst_hold) cur_dst <= cur_dst + step;
            cnt_q <= cnt_q - sz32;
            if (cnt_q == sz32) begin
              seg_set  <= 1'b1;
              lend_set <= (nxt == base);
              ptr      <= nxt;
              fidx     <= '0;
              st       <= E_FETCH;
            end else if (mode.ext_pause && acc_nx >= bwc_lim) begin
              acc <= '0;
              st  <= E_PAUSE;
            end else begin
              acc <= acc_nx;
              st  <= E_READ;
            end
          end
        end
        E_PAUSE: if (!periph_pause) st <= E_READ;
        default: st <= E_IDLE;
      endcase
    end
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy); // R10
  AST_HELD_SRC_STILL: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !abort && mode.src_hold) |=> (cur_src == $past(cur_src))); // R4
  AST_FREE_DST_STEPS: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !abort && !mode.dst_hold) |=>
      (cur_dst == $past(cur_dst) + ADDR_W'($past(mode.beat_bytes)))); // R4
  AST_PAUSE_STALLS: assert property (@(posedge clk) disable iff (rst)
    (st == E_PAUSE && periph_pause && !abort) |=> !mem_re); // R6
  AST_PERR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    perr_set |-> !busy); // R5
  AST_XERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    xerr_set |-> (!mem_we && !mem_re)); // R11
  AST_ARM_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (st == E_ARM && !periph_start) |=> !desc_rd); // R7
endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DESC_AW = 6,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               desc_rd,
  output logic [DESC_AW-1:0] desc_addr,
  input  logic [31:0]        desc_rdata,
  output logic               mem_re,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [3:0]         mem_size,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_err,
  input  logic               periph_start,
  input  logic               periph_pause,
  output logic               irq
);
  mode_t              mode;
  logic [DESC_AW-1:0] base;
  logic               go, abort, cnt_wr, busy;
  logic [31:0]        cnt_wdata, cnt_q;
  logic               seg_set, lend_set, perr_set, xerr_set;
  logic [ADDR_W-1:0]  cur_src, cur_dst;

  chain_dma_regs #(.ADDR_W(ADDR_W), .DESC_AW(DESC_AW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mode_o(mode), .base_o(base), .go_o(go), .abort_o(abort),
    .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata),
    .busy_i(busy), .seg_set_i(seg_set), .lend_set_i(lend_set),
    .perr_set_i(perr_set), .xerr_set_i(xerr_set),
    .cur_src_i(cur_src), .cur_dst_i(cur_dst), .cnt_i(cnt_q),
    .irq_o(irq)
  );

  chain_dma_engine #(.ADDR_W(ADDR_W), .DESC_AW(DESC_AW), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst),
    .mode(mode), .base(base), .go(go), .abort(abort),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .periph_start(periph_start), .periph_pause(periph_pause),
    .desc_rd(desc_rd), .desc_addr(desc_addr), .desc_rdata(desc_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .busy(busy), .seg_set(seg_set), .lend_set(lend_set),
    .perr_set(perr_set), .xerr_set(xerr_set),
    .cur_src(cur_src), .cur_dst(cur_dst), .cnt_q(cnt_q)
  );
endmodule

// File: tb/chain_dma_channel_test.sv
module chain_dma_channel_test;
  localparam int ADDR_W = 16;
  localparam int DESC_AW = 6;
  localparam int DATA_W = 64;
  localparam logic [15:0] ERR_ADDR = 16'h03F0;
  localparam int M_GO = 1, M_ABORT = 2, M_SHOLD = 4, M_DHOLD = 8, M_XSTART = 16,
                 M_XPAUSE = 32, M_SEGIE = 64, M_ERRIE = 128;

  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic desc_rd, mem_re, mem_we, mem_err, irq;
  logic [DESC_AW-1:0] desc_addr;
  logic [31:0] desc_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0] mem_size;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic periph_start = 0, periph_pause = 0;

  always #10 clk = ~clk;

  chain_dma_channel #(.ADDR_W(ADDR_W), .DESC_AW(DESC_AW), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .desc_rd(desc_rd), .desc_addr(desc_addr), .desc_rdata(desc_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .periph_start(periph_start), .periph_pause(periph_pause), .irq(irq)
  );

  logic [7:0]  bm [0:1023];
  logic [31:0] dm [0:63];

  always @(posedge clk) begin
    if (desc_rd) desc_rdata <= dm[desc_addr];
    if (mem_re) begin
      logic [63:0] t;
      t = '0;
      for (int i = 0; i < 8; i++)
        if (i < int'(mem_size)) t[8*i +: 8] = bm[(int'(mem_addr) + i) % 1024];
      mem_rdata <= t;
    end
    mem_err <= mem_re && (mem_addr == ERR_ADDR);
    if (mem_we)
      for (int i = 0; i < 8; i++)
        if (i < int'(mem_size)) bm[(int'(mem_addr) + i) % 1024] <= mem_wdata[8*i +: 8];
  end

  int checks = 0, errors = 0, wcount = 0;
  string cur_tag = "R4";

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { logic [15:0] a; logic [3:0] s; logic [63:0] d; } exp_t;
  exp_t q[$];
  bit scoring = 0;

  function automatic logic [63:0] word_at(int a, int sz);
    logic [63:0] d = '0;
    for (int i = 0; i < sz; i++) d[8*i +: 8] = bm[a + i];
    return d;
  endfunction

  task automatic push(int a, int sz, logic [63:0] d);
    exp_t e;
    e.a = 16'(a); e.s = 4'(sz); e.d = d;
    q.push_back(e);
    scoring = 1;
  endtask

  always @(negedge clk) begin
    if (mem_we) begin
      wcount++;
      if (scoring && q.size() > 0) begin
        exp_t e;
        logic [63:0] m;
        e = q.pop_front();
        m = '0;
        for (int i = 0; i < 8; i++) if (i < int'(mem_size)) m[8*i +: 8] = mem_wdata[8*i +: 8];
        chk(cur_tag, {mem_addr, mem_size, m, 12'h0}, {e.a, e.s, e.d, 12'h0});
        if (q.size() == 0) scoring = 0;
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    repeat (3) @(negedge clk);
    reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int w0;
    for (int i = 0; i < 1024; i++) bm[i] = 8'(i + 16);
    bm[16'h310] = 8'hA5; bm[16'h311] = 8'h5A;
    for (int i = 0; i < 64; i++) dm[i] = 0;
    dm[0] = 0;      dm[1] = 32'h300; dm[2] = 8;  dm[3] = 4;
    dm[4] = 8;      dm[5] = 32'h300; dm[6] = 8;  dm[7] = 0;
    dm[8] = 32'h310; dm[9] = 32'h100; dm[10] = 6; dm[11] = 8;
    dm[12] = 0;     dm[13] = 32'h200; dm[14] = 0; dm[15] = 12;
    dm[16] = 0;     dm[17] = 32'h200; dm[18] = 16; dm[19] = 16;
    dm[20] = 32'h3F0; dm[21] = 32'h200; dm[22] = 4; dm[23] = 20;
    repeat (5) @(negedge clk);
    rst = 0;

    // Reset state: R12 busy low, R3 irq low
    rd(3'd1, v); chk("R12", 96'(v), 96'h0);
    rd(3'd0, v); chk("R12", 96'(v), 96'h0);
    chk("R3", 96'(irq), 96'h0);

    // Two-descriptor ring, destination held, 4-byte beats: R1 R2 R4
    cur_tag = "R1";
    for (int lap = 0; lap < 2; lap++)
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < 2; k++) push(32'h300, 4, word_at(d*8 + k*4, 4));
    wr(3'd2, 0);
    wr(3'd0, M_DHOLD | M_SEGIE | (4 << 8) | M_GO);
    drain();
    rd(3'd1, v); chk("R2", 96'(v), 96'h13);
    chk("R3", 96'(irq), 96'h1);
    rd(3'd5, v); chk("R4", 96'(v), 96'h300);
    wr(3'd0, M_DHOLD | M_SEGIE | (4 << 8) | M_ABORT);
    rd(3'd1, v); chk("R10", 96'(v), 96'h03);
    wr(3'd1, 32'h1);
    rd(3'd1, v); chk("R9", 96'(v), 96'h02);
    chk("R3", 96'(irq), 96'h0);
    wr(3'd1, 32'h2);

    // Self-looping descriptor, source held, 2-byte beats: R4
    cur_tag = "R4";
    for (int k = 0; k < 6; k++) push(32'h100 + 2*(k % 3), 2, 64'h5AA5);
    wr(3'd2, 8);
    wr(3'd0, M_SHOLD | (2 << 8) | M_GO);
    drain();
    wr(3'd0, M_ABORT);
    rd(3'd4, v); chk("R4", 96'(v), 96'h310);
    wr(3'd1, 32'hF);

    // Bad beat size and zero count: R5
    w0 = wcount;
    wr(3'd0, M_ERRIE | (3 << 8) | M_GO);
    rd(3'd1, v); chk("R5", 96'(v), 96'h04);
    chk("R3", 96'(irq), 96'h1);
    wr(3'd1, 32'hF);
    wr(3'd2, 12);
    wr(3'd0, (1 << 8) | M_GO);
    repeat (10) @(negedge clk);
    rd(3'd1, v); chk("R5", 96'(v), 96'h04);
    chk("R5", 96'(wcount - w0), 96'h0);
    wr(3'd1, 32'hF);

    // Non-zero byte count with external pause: R8
    wr(3'd3, 5);
    rd(3'd3, v); chk("R12", 96'(v), 96'h5);
    wr(3'd0, M_XPAUSE | (1 << 8) | M_GO);
    rd(3'd1, v); chk("R8", 96'(v), 96'h04);
    wr(3'd1, 32'hF);
    wr(3'd3, 0);

    // External start then pause window of 4 bytes: R7 R6
    cur_tag = "R6";
    for (int i = 0; i < 16; i++) push(32'h200 + i, 1, word_at(i, 1));
    wr(3'd2, 16);
    periph_pause = 1;
    wr(3'd0, M_XSTART | M_XPAUSE | (1 << 8) | (2 << 12) | M_GO);
    repeat (10) @(negedge clk);
    rd(3'd1, v); chk("R7", 96'(v), 96'h0);
    chk("R7", 96'(q.size()), 96'd16);
    @(negedge clk); periph_start = 1;
    @(negedge clk); periph_start = 0;
    repeat (30) @(negedge clk);
    chk("R6", 96'(q.size()), 96'd12);
    rd(3'd3, v); chk("R12", 96'(v), 96'd12);
    rd(3'd4, v); chk("R12", 96'(v), 96'h4);
    rd(3'd1, v); chk("R12", 96'(v[4]), 96'h1);
    periph_pause = 0;
    drain();
    wr(3'd0, M_ABORT);
    wr(3'd1, 32'hF);

    // Read error: R11
    w0 = wcount;
    wr(3'd2, 20);
    wr(3'd0, M_ERRIE | (4 << 8) | M_GO);
    repeat (20) @(negedge clk);
    rd(3'd1, v); chk("R11", 96'(v), 96'h08);
    chk("R11", 96'(wcount - w0), 96'h0);
    chk("R3", 96'(irq), 96'h1);

    finish_run();
  end
endmodule